// File: doc/BRIEF.md
# Banked Lane Scratchpad with Conflict Replay

A scratchpad of word-wide storage shared by a group of parallel lanes. Every lane can present one word access (read or full-word write) in the same cycle as a single group request. Storage is interleaved across single-ported banks, with consecutive word addresses landing in consecutive banks. All lanes whose banks are not contested are served in the first cycle. Lanes that contest a bank are served over extra cycles, one per bank per cycle, the lowest-numbered lane first.

A controller issues a group with a one-cycle `grp_start` strobe and waits for `done`. While replay rounds are pending, `busy` is high and further strobes are dropped. When `done` pulses, each reading lane's result sits in its own output register. `degree` gives the number of cycles the group occupied.

The control is a two-state machine:
- **IDLE** serves the first round directly from the ports. Its transitions are:
  - IDLE→IDLE when there is no strobe, or when every lane is served in that round.
  - IDLE→REPLAY when lanes remain.
- **REPLAY** serves the latched, still-pending lanes. Its transitions are:
  - REPLAY→REPLAY while lanes remain.
  - REPLAY→IDLE when the last lane is served.

Top module: `sp_banked_scratch`

## Requirements
- R1: With BANKS = 16, a word address selects bank `addr % 16` and row `addr / 16`. A word written by a lane is returned by a later read of that address.
- R2: A group whose valid lanes all hit different banks completes in one cycle: `done` is high in the cycle after the strobe edge, and `degree` is 1.
- R3: When several lanes hit one bank, the lane with the lowest index is served first. For writes to the same address in one group, the highest-indexed writer's data remains.
- R4: `done` rises `degree` cycles after the strobe edge. `degree` equals the largest number of valid lanes mapped to any single bank.
- R5: `busy` is high from the strobe edge of a conflicting group until `done`, and never together with `done`. A `grp_start` while busy has no effect on storage.
- R6: A lane's read register changes only when that lane performs a read. Lanes that are invalid or writing keep their previous value.
- R7: A strobe with no valid lane gives `done` in the next cycle with `degree` 0, and changes no storage.
- R8: After reset, `busy`, `done`, `degree` and every read register are 0.
- R9: Within one group, accesses to the same bank take effect in lane order. A read by a higher lane sees a write by a lower lane, and a read by a lower lane sees the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_start | input | 1 | Group request strobe |
| lane_valid | input | LANES | Per-lane access enable |
| lane_we | input | LANES | Per-lane write (1) or read (0) |
| lane_addr | input | LANES*AW | Per-lane word address, lane 0 in the low bits |
| lane_wdata | input | LANES*DW | Per-lane write word |
| busy | output | 1 | Replay rounds pending |
| done | output | 1 | One-cycle pulse: group finished |
| degree | output | CW | Cycles used by the last group |
| lane_rdata | output | LANES*DW | Per-lane held read word |

## Verification
The bench uses the defaults: 16 lanes, 16 banks, 32-bit words and 8-bit word addresses, giving 16 rows per bank. With this size, the whole storage can be filled and read back in 16 conflict-free groups. The worst case of all sixteen lanes on one bank, and so the full degree of 16, is also within reach. Random groups that draw their bank from only four values make multi-round replays and mixed read/write ordering inside a bank frequent.

// File: rtl/sp_pkg.sv
package sp_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_REPLAY = 1'b1
    } sp_state_e;
endpackage

// File: rtl/sp_arb.sv
// Lowest-index-wins grant among lanes requesting one bank.
module sp_arb #(
    parameter int N = 16
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    assign gnt = req & (~req + N'(1));
endmodule

// File: rtl/sp_bank.sv
// One single-ported bank: write at the edge, read combinationally.
module sp_bank #(
    parameter int DW = 32,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          wen,
    input  logic [RW-1:0] row,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] rd
);
    localparam int DEPTH = 1 << RW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wen) mem[row] <= wd;
    end

    assign rd = mem[row];
endmodule

// File: rtl/sp_banked_scratch.sv
module sp_banked_scratch
    import sp_pkg::*;
#(
    parameter int LANES = 16,
    parameter int BANKS = 16,
    parameter int DW    = 32,
    parameter int AW    = 8,
    localparam int CW   = $clog2(LANES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                grp_start,
    input  logic [LANES-1:0]    lane_valid,
    input  logic [LANES-1:0]    lane_we,
    input  logic [LANES*AW-1:0] lane_addr,
    input  logic [LANES*DW-1:0] lane_wdata,
    output logic                busy,
    output logic                done,
    output logic [CW-1:0]       degree,
    output logic [LANES*DW-1:0] lane_rdata
);
    localparam int BW = $clog2(BANKS);
    localparam int RW = AW - BW;

    sp_state_e state_q;
    logic [LANES-1:0]    pend_q, lat_we_q;
    logic [LANES*AW-1:0] lat_addr_q;
    logic [LANES*DW-1:0] lat_wd_q;
    logic [CW-1:0]       cnt_q;
    logic                done_q;
    logic [CW-1:0]       degree_q;
    logic [DW-1:0]       rd_q [LANES];

    logic idle, take;
    logic [LANES-1:0]    cur_mask, cur_we, lane_gnt, remain;
    logic [LANES*AW-1:0] cur_addr_f;
    logic [LANES*DW-1:0] cur_wd_f;
    logic [AW-1:0]       cur_addr [LANES];
    logic [DW-1:0]       cur_wd   [LANES];
    logic [LANES-1:0]    bank_req [BANKS];
    logic [LANES-1:0]    bank_gnt [BANKS];
    logic [RW-1:0]       bank_row [BANKS];
    logic                bank_wen [BANKS];
    logic [DW-1:0]       bank_wd  [BANKS];
    logic [DW-1:0]       bank_rd  [BANKS];

    assign idle       = (state_q == ST_IDLE);
    assign take       = idle && grp_start;
    assign cur_mask   = idle ? (grp_start ? lane_valid : '0) : pend_q;
    assign cur_we     = idle ? lane_we    : lat_we_q;
    assign cur_addr_f = idle ? lane_addr  : lat_addr_q;
    assign cur_wd_f   = idle ? lane_wdata : lat_wd_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign cur_addr[l] = cur_addr_f[l*AW +: AW];
        assign cur_wd[l]   = cur_wd_f[l*DW +: DW];
        assign lane_rdata[l*DW +: DW] = rd_q[l];
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        always_comb begin
            for (int l = 0; l < LANES; l++)
                bank_req[b][l] = cur_mask[l] && (cur_addr[l][BW-1:0] == BW'(b));
        end

        sp_arb #(.N(LANES)) u_arb (.req(bank_req[b]), .gnt(bank_gnt[b]));

        always_comb begin
            bank_row[b] = '0;
            bank_wen[b] = 1'b0;
            bank_wd[b]  = '0;
            for (int l = 0; l < LANES; l++) begin
                if (bank_gnt[b][l]) begin
                    bank_row[b] = bank_row[b] | cur_addr[l][AW-1:BW];
                    bank_wen[b] = bank_wen[b] | cur_we[l];
                    bank_wd[b]  = bank_wd[b]  | cur_wd[l];
                end
            end
        end

        sp_bank #(.DW(DW), .RW(RW)) u_bank (
            .clk (clk),
            .wen (bank_wen[b]),
            .row (bank_row[b]),
            .wd  (bank_wd[b]),
            .rd  (bank_rd[b])
        );
    end

    always_comb begin
        lane_gnt = '0;
        for (int b = 0; b < BANKS; b++) lane_gnt = lane_gnt | bank_gnt[b];
    end
    assign remain = cur_mask & ~lane_gnt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (take && remain != '0) state_q <= ST_REPLAY;
                ST_REPLAY: if (remain == '0)         state_q <= ST_IDLE;
            endcase
        end
    end

    // Pending lanes and the latched group
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= '0;
            lat_we_q   <= '0;
            lat_addr_q <= '0;
            lat_wd_q   <= '0;
            cnt_q      <= '0;
        end else begin
            pend_q <= remain;
            if (take) begin
                lat_we_q   <= lane_we;
                lat_addr_q <= lane_addr;
                lat_wd_q   <= lane_wdata;
                cnt_q      <= CW'(1);
            end else if (!idle) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            degree_q <= '0;
            for (int l = 0; l < LANES; l++) rd_q[l] <= '0;
        end else begin
            done_q <= (take || !idle) && (remain == '0);
            if (take && remain == '0)
                degree_q <= (lane_valid != '0) ? CW'(1) : CW'(0);
            else if (!idle && remain == '0)
                degree_q <= cnt_q + CW'(1);
            for (int l = 0; l < LANES; l++)
                if (lane_gnt[l] && !cur_we[l])
                    rd_q[l] <= bank_rd[cur_addr[l][BW-1:0]];
        end
    end

    assign busy   = (state_q == ST_REPLAY);
    assign done   = done_q;
    assign degree = degree_q;

    // R5: completion only once the machine has left replay
    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5: a strobe during replay leaves the latched group untouched
    p_ignore_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REPLAY) |=> ($stable(lat_addr_q) && $stable(lat_wd_q) && $stable(lat_we_q)));

    // R3: each replay round serves at least one pending lane
    p_progress_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REPLAY) |=> ($countones(pend_q) < $countones($past(pend_q))));

    // R4: a group that needed replay reports at least two cycles
    p_multi_degree_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(state_q == ST_REPLAY)) |-> (degree >= CW'(2)));

    // R4: degree never exceeds the lane count
    p_degree_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (degree <= CW'(LANES)));
endmodule

// File: tb/sim_sp_banked_scratch.sv
`timescale 1ns/1ps
module sim_sp_banked_scratch;
    localparam int L = 16, DW = 32, AW = 8, CW = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic grp_start = 1'b0;
    logic [L-1:0] lane_valid = '0, lane_we = '0;
    logic [L*AW-1:0] lane_addr = '0;
    logic [L*DW-1:0] lane_wdata = '0;
    logic busy, done;
    logic [CW-1:0] degree;
    logic [L*DW-1:0] lane_rdata;

    always #4 clk = ~clk;

    sp_banked_scratch u0 (
        .clk(clk), .rst_n(rst_n), .grp_start(grp_start),
        .lane_valid(lane_valid), .lane_we(lane_we), .lane_addr(lane_addr),
        .lane_wdata(lane_wdata), .busy(busy), .done(done),
        .degree(degree), .lane_rdata(lane_rdata)
    );

    int checks = 0, errors = 0;
    logic [31:0] ref_mem [256];
    logic [31:0] hold [L];
    logic [L-1:0] g_v, g_we;
    logic [7:0]  g_a [L];
    logic [31:0] g_d [L];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int model_degree();
        int cnt [16];
        int m = 0;
        for (int b = 0; b < 16; b++) cnt[b] = 0;
        for (int l = 0; l < L; l++) if (g_v[l]) cnt[g_a[l][3:0]]++;
        for (int b = 0; b < 16; b++) if (cnt[b] > m) m = cnt[b];
        return m;
    endfunction

    // Lane-ascending order per bank (R3, R9); banks are independent.
    function automatic void model_apply();
        for (int l = 0; l < L; l++)
            if (g_v[l]) begin
                if (g_we[l]) ref_mem[g_a[l]] = g_d[l];
                else         hold[l] = ref_mem[g_a[l]];
            end
    endfunction

    task automatic run_group(input string tag, input bit poke);
        int deg, k;
        bit poked;
        deg = model_degree();
        @(negedge clk);
        lane_valid = g_v; lane_we = g_we;
        for (int l = 0; l < L; l++) begin
            lane_addr[l*AW +: AW]  = g_a[l];
            lane_wdata[l*DW +: DW] = g_d[l];
        end
        grp_start = 1'b1;
        model_apply();
        @(posedge clk); @(negedge clk);
        grp_start = 1'b0;
        k = 1; poked = 1'b0;
        while (!done && k < 40) begin
            chk({tag, " R5 busy during replay"}, 32'(busy), 32'd1);
            if (poke && !poked) begin
                lane_valid = '1; lane_we = '1;
                for (int l = 0; l < L; l++) begin
                    lane_addr[l*AW +: AW]  = 8'(l);
                    lane_wdata[l*DW +: DW] = 32'hDEAD0000 | 32'(l);
                end
                grp_start = 1'b1; poked = 1'b1;
            end
            @(posedge clk); @(negedge clk);
            grp_start = 1'b0;
            k++;
        end
        chk({tag, " R4 cycles to done"}, 32'(k), 32'((deg == 0) ? 1 : deg));
        chk({tag, " R4 degree"}, 32'(degree), 32'(deg));
        chk({tag, " R5 busy low at done"}, 32'(busy), 32'd0);
        for (int l = 0; l < L; l++)
            chk({tag, " R6 R9 lane read"}, lane_rdata[l*DW +: DW], hold[l]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int l = 0; l < L; l++) hold[l] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8 reset state
        chk("R8 busy", 32'(busy), 0);
        chk("R8 done", 32'(done), 0);
        chk("R8 degree", 32'(degree), 0);
        for (int l = 0; l < L; l++) chk("R8 rdata", lane_rdata[l*DW +: DW], 0);
        rst_n = 1'b1;

        // R1 R2: fill storage with conflict-free groups
        for (int g = 0; g < 16; g++) begin
            g_v = '1; g_we = '1;
            for (int l = 0; l < L; l++) begin g_a[l] = 8'(g*16 + l); g_d[l] = $urandom; end
            run_group("R2 fill", 1'b0);
        end

        // R4: all lanes read one bank, distinct rows -> degree 16
        g_v = '1; g_we = '0;
        for (int l = 0; l < L; l++) g_a[l] = 8'(l*16 + 3);
        run_group("R4 same bank", 1'b0);

        // R3: all lanes write one address, highest lane survives
        g_v = '1; g_we = '1;
        for (int l = 0; l < L; l++) begin g_a[l] = 8'd5; g_d[l] = 32'hA5A50000 | 32'(l); end
        run_group("R3 same addr write", 1'b0);
        g_v = 16'h0001; g_we = '0; g_a[0] = 8'd5;
        run_group("R3 readback", 1'b0);

        // R9: lane order within a bank
        g_v = '0; g_we = '0;
        g_v[2] = 1; g_we[2] = 1; g_a[2] = 8'd40; g_d[2] = 32'h12345678;
        g_v[7] = 1; g_a[7] = 8'd40;
        g_v[3] = 1; g_a[3] = 8'd41;
        g_v[9] = 1; g_we[9] = 1; g_a[9] = 8'd41; g_d[9] = 32'h87654321;
        run_group("R9 order", 1'b0);

        // R7: empty group, garbage on invalid lanes
        g_v = '0; g_we = '1;
        for (int l = 0; l < L; l++) begin g_a[l] = 8'(l); g_d[l] = 32'hFFFFFFFF; end
        run_group("R7 empty", 1'b0);

        // R5: strobe during replay is dropped (row 0 checked in readback)
        g_v = '1; g_we = '0;
        for (int l = 0; l < L; l++) g_a[l] = 8'(l*16 + 9);
        run_group("R5 poke", 1'b1);

        // R6: partial group, other lanes hold
        g_v = 16'h0021; g_we = '0; g_a[0] = 8'd100; g_a[5] = 8'd200;
        run_group("R6 partial", 1'b0);

        // Random groups, half with bank drawn from four values
        for (int n = 0; n < 60; n++) begin
            g_v = 16'($urandom); g_we = 16'($urandom);
            for (int l = 0; l < L; l++) begin
                g_a[l] = 8'($urandom);
                if (n % 2 == 1) g_a[l][3:0] = 4'($urandom % 4);
                g_d[l] = $urandom;
            end
            run_group("R4 random", 1'b0);
        end

        // R1 R5: full readback against the model
        for (int g = 0; g < 16; g++) begin
            g_v = '1; g_we = '0;
            for (int l = 0; l < L; l++) g_a[l] = 8'(g*16 + l);
            run_group("R1 readback", 1'b0);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule